// File: doc/BRIEF.md
# Synchronous Serial Slave Receiver

This block receives serial words clocked in by an external device. The remote end drives both a serial clock and a data line. The block brings both into the local clock domain through a two-flop synchronizer. It samples one data bit on each rising edge of the synchronized serial clock, least significant bit first, into a shift register. When the last bit of a word has arrived, the word moves into a two-entry receive buffer. A receive-complete flag then rises, and an interrupt request rises with it if the receive interrupt enable is set. The request can also serve as a wake-up, because reception needs no local activity beyond the clock that samples the pins.

Software reads the block through a one-bit-addressed read port. Address 0 returns status: the ninth bit of the oldest word, the overrun flag, the framing flag and the receive-complete flag. Address 1 returns the low data bits of the oldest word, and a read strobe at that address removes the word from the buffer. Status must be read before data, because the ninth bit belongs to the word at the head of the buffer. Errors stay set until software drops the continuous-receive enable.

Top module: `sync_slave_rx`

## Requirements
- R1: After reset, `rx_done_o` and `irq_o` are 0, and the status read (`rd_addr_i`=0) returns 0.
- R2: The block shifts in bits only while `port_en_i`=1, `sync_mode_i`=1, `clk_src_i`=0 and `cont_rx_i`=1. The single-word request input `single_rx_i` has no effect in any state.
- R3: The block samples data on the low-to-high transition of `sclk_i`, least significant bit first. With `nine_bit_i`=0 a word is 8 bits, the data read (`rd_addr_i`=1) returns it, and status bit 0 reads 0.
- R4: With `nine_bit_i`=1 a word is 9 bits. The data read returns the first eight bits, and status bit 0 holds the ninth (last received) bit of the oldest buffered word.
- R5: A completed word sets `rx_done_o` (also status bit 3). A data read with the `rd_en_i` strobe removes the oldest word, and words come out in arrival order. The flag stays 1 while a second buffered word remains and falls when the buffer empties.
- R6: `irq_o` is 1 exactly when `rx_done_o`=1 and `rx_ie_i`=1.
- R7: If a word completes while both buffer entries are full and no data read happens in that cycle, status bit 1 (overrun) sets and the new word is discarded. The block ignores further words until the error is cleared, and the buffered words stay readable.
- R8: Setting `cont_rx_i` to 0 clears the overrun flag and resets the bit counter, which abandons a partly received word.
- R9: Status bit 2 (framing) always reads 0 in this clocked mode.
- R10: A word that completes in the same cycle as a data read on a full buffer is accepted without overrun.
- R11: Reading status (`rd_addr_i`=0, even with `rd_en_i`=1) does not change the buffer or flags. A data read on an empty buffer returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Local clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| port_en_i | input | 1 | Port enable |
| sync_mode_i | input | 1 | 1 selects clocked (synchronous) operation |
| clk_src_i | input | 1 | 1 = local clock source (master); 0 = external clock (slave) |
| cont_rx_i | input | 1 | Continuous-receive enable; 0 clears errors |
| single_rx_i | input | 1 | Single-word request; no effect in slave mode |
| nine_bit_i | input | 1 | 1 selects 9-bit words |
| rx_ie_i | input | 1 | Receive interrupt enable |
| sclk_i | input | 1 | External serial clock |
| sdata_i | input | 1 | Serial data |
| rd_en_i | input | 1 | Read strobe |
| rd_addr_i | input | 1 | 0 = status, 1 = data |
| rd_data_o | output | 8 | Read data |
| rx_done_o | output | 1 | Receive-complete flag |
| irq_o | output | 1 | Interrupt / wake request |

## Verification
Two events can land in the same local cycle: a word entering the buffer and software taking the oldest word out. The bench fills both entries first. It then counts synchronizer and shifter stages from the final serial clock rise, so that the data read strobe lines up with the cycle in which the third word is pushed. The result is judged at the ports: the overrun bit must stay 0, and the three words must come out in order. A separate run with no read in that cycle must set overrun and drop the word.

// File: rtl/sync_rx_pkg.sv
package sync_rx_pkg;
  localparam int unsigned DATA_W = 8;
  localparam int unsigned SYNC_STAGES = 2;
  localparam int unsigned BUF_DEPTH = 2;

  // status bit positions
  localparam int unsigned ST_NINTH = 0;
  localparam int unsigned ST_OVR   = 1;
  localparam int unsigned ST_FERR  = 2;
  localparam int unsigned ST_DONE  = 3;

  typedef enum logic {
    ADDR_STAT = 1'b0,
    ADDR_DATA = 1'b1
  } rd_addr_e;
endpackage

// File: rtl/sync_rx_edge.sv
module sync_rx_edge #(
  parameter int unsigned STAGES = sync_rx_pkg::SYNC_STAGES
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sclk_i,
  input  logic sdata_i,
  output logic rise_o,
  output logic data_o
);
  logic [STAGES-1:0] ck_q, dt_q;
  logic              ck_prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ck_q      <= '0;
      dt_q      <= '0;
      ck_prev_q <= 1'b0;
    end else begin
      ck_q      <= {ck_q[STAGES-2:0], sclk_i};
      dt_q      <= {dt_q[STAGES-2:0], sdata_i};
      ck_prev_q <= ck_q[STAGES-1];
    end
  end

  assign rise_o = ck_q[STAGES-1] & ~ck_prev_q;
  assign data_o = dt_q[STAGES-1];

  AST_RISE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o); // R3
endmodule

// File: rtl/sync_rx_shift.sv
module sync_rx_shift #(
  parameter int unsigned DATA_W = sync_rx_pkg::DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              nine_i,
  input  logic              rise_i,
  input  logic              bit_i,
  output logic [DATA_W:0]   word_o,
  output logic              vld_o
);
  localparam int unsigned W  = DATA_W + 1;
  localparam int unsigned CW = $clog2(W + 1);

  logic [CW-1:0] cnt_q;
  logic [W-1:0]  sh_q, sh_nx;
  logic          last;

  assign last = nine_i ? (cnt_q >= CW'(W - 1)) : (cnt_q >= CW'(DATA_W - 1));

  always_comb begin
    sh_nx = (cnt_q == '0) ? '0 : sh_q;
    sh_nx[cnt_q] = bit_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      sh_q   <= '0;
      word_o <= '0;
      vld_o  <= 1'b0;
    end else if (!en_i) begin
      cnt_q <= '0;
      vld_o <= 1'b0;
    end else begin
      vld_o <= 1'b0;
      if (rise_i) begin
        sh_q <= sh_nx;
        if (last) begin
          cnt_q  <= '0;
          word_o <= sh_nx;
          vld_o  <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  AST_CNT_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < CW'(W)); // R3
  AST_ABANDON: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (cnt_q == '0) && !vld_o); // R8
endmodule

// File: rtl/sync_rx_fifo.sv
module sync_rx_fifo #(
  parameter int unsigned WIDTH = sync_rx_pkg::DATA_W + 1,
  parameter int unsigned DEPTH = sync_rx_pkg::BUF_DEPTH
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic             pop_i,
  input  logic [WIDTH-1:0] wdata_i,
  output logic [WIDTH-1:0] rdata_o,
  output logic             empty_o,
  output logic             full_o
);
  localparam int unsigned AW  = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CNW = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [AW-1:0]    rd_q, wr_q;
  logic [CNW-1:0]   cnt_q;

  function automatic logic [AW-1:0] inc(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CNW'(DEPTH));
  assign rdata_o = mem_q[rd_q];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= '0;
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else begin
      if (push_i) begin
        mem_q[wr_q] <= wdata_i;
        wr_q        <= inc(wr_q);
      end
      if (pop_i) rd_q <= inc(rd_q);
      if (push_i && !pop_i)      cnt_q <= cnt_q + 1'b1;
      else if (pop_i && !push_i) cnt_q <= cnt_q - 1'b1;
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i && !pop_i |-> !full_o); // R7
  AST_NO_UNDERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> !empty_o); // R11
endmodule

// File: rtl/sync_slave_rx.sv
module sync_slave_rx
  import sync_rx_pkg::*;
#(
  parameter int unsigned DW = DATA_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          port_en_i,
  input  logic          sync_mode_i,
  input  logic          clk_src_i,
  input  logic          cont_rx_i,
  input  logic          single_rx_i,
  input  logic          nine_bit_i,
  input  logic          rx_ie_i,
  input  logic          sclk_i,
  input  logic          sdata_i,
  input  logic          rd_en_i,
  input  logic          rd_addr_i,
  output logic [DW-1:0] rd_data_o,
  output logic          rx_done_o,
  output logic          irq_o
);
  localparam int unsigned WW = DW + 1;

  logic          rise, sbit, slave_sel, rx_en;
  logic          word_vld, push, pop, empty, full;
  logic [WW-1:0] word, head;
  logic          ovr_q;
  logic [DW-1:0] stat;
  rd_addr_e      addr;

  assign addr      = rd_addr_e'(rd_addr_i);
  // single_rx_i deliberately unused: no meaning in slave mode
  assign slave_sel = port_en_i & sync_mode_i & ~clk_src_i;
  assign rx_en     = slave_sel & cont_rx_i & ~ovr_q;

  sync_rx_edge #(.STAGES(SYNC_STAGES)) u_edge (
    .clk_i, .rst_ni, .sclk_i, .sdata_i,
    .rise_o (rise),
    .data_o (sbit)
  );

  sync_rx_shift #(.DATA_W(DW)) u_shift (
    .clk_i, .rst_ni,
    .en_i   (rx_en),
    .nine_i (nine_bit_i),
    .rise_i (rise),
    .bit_i  (sbit),
    .word_o (word),
    .vld_o  (word_vld)
  );

  assign pop  = rd_en_i & (addr == ADDR_DATA) & ~empty;
  assign push = word_vld & ~ovr_q & (~full | pop);

  sync_rx_fifo #(.WIDTH(WW), .DEPTH(BUF_DEPTH)) u_buf (
    .clk_i, .rst_ni,
    .push_i  (push),
    .pop_i   (pop),
    .wdata_i (word),
    .rdata_o (head),
    .empty_o (empty),
    .full_o  (full)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          ovr_q <= 1'b0;
    else if (!cont_rx_i)                  ovr_q <= 1'b0;
    else if (word_vld && full && !pop)    ovr_q <= 1'b1;
  end

  assign rx_done_o = ~empty;
  assign irq_o     = rx_done_o & rx_ie_i;

  always_comb begin
    stat           = '0;
    stat[ST_NINTH] = ~empty & head[DW];
    stat[ST_OVR]   = ovr_q;
    stat[ST_FERR]  = 1'b0;
    stat[ST_DONE]  = ~empty;
  end

  assign rd_data_o = (addr == ADDR_STAT) ? stat : (empty ? '0 : head[DW-1:0]);

  AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> rx_done_o); // R6
  AST_OVR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovr_q && cont_rx_i |=> ovr_q); // R7
  AST_OVR_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cont_rx_i |=> !ovr_q); // R8
  AST_DONE_AFTER_PUSH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push |=> rx_done_o); // R5
  AST_NO_PUSH_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !slave_sel |=> !word_vld); // R2
endmodule

// File: tb/tb_sync_slave_rx.sv
module tb_sync_slave_rx;
  localparam int unsigned CLK_PERIOD = 10;

  logic       clk = 1'b0, rst_ni = 1'b0;
  logic       port_en, sync_mode, clk_src, cont_rx, single_rx, nine_bit, rx_ie;
  logic       sclk, sdata, rd_en, rd_addr;
  logic [7:0] rd_data;
  logic       rx_done, irq;
  int         n_vec = 0, n_bad = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  sync_slave_rx dut (
    .clk_i(clk), .rst_ni, .port_en_i(port_en), .sync_mode_i(sync_mode),
    .clk_src_i(clk_src), .cont_rx_i(cont_rx), .single_rx_i(single_rx),
    .nine_bit_i(nine_bit), .rx_ie_i(rx_ie), .sclk_i(sclk), .sdata_i(sdata),
    .rd_en_i(rd_en), .rd_addr_i(rd_addr), .rd_data_o(rd_data),
    .rx_done_o(rx_done), .irq_o(irq)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic send_bit(input logic b);
    @(negedge clk) sdata = b;
    repeat (3) @(negedge clk);
    sclk = 1'b1;
    repeat (4) @(negedge clk);
    sclk = 1'b0;
  endtask

  task automatic send_word(input logic [8:0] w, input int n);
    for (int i = 0; i < n; i++) send_bit(w[i]);
    repeat (3) @(negedge clk);
  endtask

  task automatic rd_stat(output logic [7:0] v);
    @(negedge clk);
    rd_addr = 1'b0; rd_en = 1'b1;
    #1 v = rd_data;
    @(negedge clk) rd_en = 1'b0;
  endtask

  task automatic rd_word(output logic [7:0] v);
    @(negedge clk);
    rd_addr = 1'b1; rd_en = 1'b1;
    #1 v = rd_data;
    @(negedge clk) rd_en = 1'b0;
    rd_addr = 1'b0;
  endtask

  task automatic drop_cont();
    @(negedge clk) cont_rx = 1'b0;
    repeat (2) @(negedge clk);
    cont_rx = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_reset();
    logic [7:0] v;
    #1;
    chk("R1 done", rx_done, 0);
    chk("R1 irq", irq, 0);
    rd_stat(v);
    chk("R1 status", v, 8'h00);
  endtask

  task automatic t_basic8();
    logic [7:0] v;
    send_word(9'h0A5, 8);
    chk("R5 done set", rx_done, 1);
    rd_stat(v);
    chk("R3 ninth zero / R9 ferr zero / R5 done bit", v, 8'h08);
    chk("R11 status read keeps flag", rx_done, 1);
    rd_word(v);
    chk("R3 data lsb first", v, 8'hA5);
    #1 chk("R5 flag clears", rx_done, 0);
    rd_word(v);
    chk("R11 empty read zero", v, 8'h00);
  endtask

  task automatic t_nine();
    logic [7:0] v;
    nine_bit = 1'b1;
    send_word(9'h13C, 9);
    send_word(9'h0C3, 9);
    rd_stat(v);
    chk("R4 ninth bit set", v, 8'h09);
    rd_word(v);
    chk("R4 low byte", v, 8'h3C);
    rd_stat(v);
    chk("R4 ninth bit clear", v, 8'h08);
    rd_word(v);
    chk("R4 second low byte", v, 8'hC3);
    nine_bit = 1'b0;
  endtask

  task automatic t_gate();
    clk_src = 1'b1;
    send_word(9'h055, 8);
    #1 chk("R2 master clock blocks", rx_done, 0);
    clk_src = 1'b0; sync_mode = 1'b0;
    send_word(9'h055, 8);
    #1 chk("R2 async blocks", rx_done, 0);
    sync_mode = 1'b1; port_en = 1'b0;
    send_word(9'h055, 8);
    #1 chk("R2 port off blocks", rx_done, 0);
    port_en = 1'b1; cont_rx = 1'b0; single_rx = 1'b1;
    send_word(9'h055, 8);
    #1 chk("R2 single request ignored", rx_done, 0);
    cont_rx = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_two_deep_irq();
    logic [7:0] v;
    rx_ie = 1'b1;
    send_word(9'h011, 8);
    #1 chk("R6 irq with enable", irq, 1);
    send_word(9'h022, 8);
    rd_word(v);
    chk("R5 order first", v, 8'h11);
    #1 chk("R5 flag held second waiting", rx_done, 1);
    rx_ie = 1'b0;
    #1 chk("R6 irq masked", irq, 0);
    rd_word(v);
    chk("R5 order second", v, 8'h22);
    #1 chk("R5 flag clear empty", rx_done, 0);
  endtask

  task automatic t_overrun();
    logic [7:0] v;
    send_word(9'h0A1, 8);
    send_word(9'h0B2, 8);
    send_word(9'h0C3, 8);
    rd_stat(v);
    chk("R7 overrun set", v, 8'h0A);
    send_word(9'h0D4, 8);
    rd_word(v);
    chk("R7 buffered first kept", v, 8'hA1);
    rd_word(v);
    chk("R7 buffered second kept", v, 8'hB2);
    #1 chk("R7 dropped word absent", rx_done, 0);
    rd_stat(v);
    chk("R7 overrun sticky", v, 8'h02);
    drop_cont();
    rd_stat(v);
    chk("R8 overrun cleared", v, 8'h00);
    send_word(9'h0E5, 8);
    rd_word(v);
    chk("R8 receives after clear", v, 8'hE5);
  endtask

  task automatic t_abandon();
    logic [7:0] v;
    send_bit(1'b1); send_bit(1'b1); send_bit(1'b1);
    drop_cont();
    send_word(9'h06C, 8);
    rd_word(v);
    chk("R8 partial abandoned", v, 8'h6C);
    #1 chk("R8 single word only", rx_done, 0);
  endtask

  task automatic t_collide();
    logic [7:0] v;
    logic [7:0] w;
    send_word(9'h031, 8);
    send_word(9'h042, 8);
    w = 8'h97;
    for (int i = 0; i < 7; i++) send_bit(w[i]);
    @(negedge clk) sdata = w[7];
    repeat (3) @(negedge clk);
    sclk = 1'b1;
    repeat (3) @(negedge clk);
    rd_addr = 1'b1; rd_en = 1'b1;
    #1 v = rd_data;
    chk("R10 head during collision", v, 8'h31);
    @(negedge clk) rd_en = 1'b0;
    rd_addr = 1'b0;
    repeat (3) @(negedge clk);
    sclk = 1'b0;
    rd_stat(v);
    chk("R10 no overrun", v, 8'h08);
    rd_word(v);
    chk("R10 second", v, 8'h42);
    rd_word(v);
    chk("R10 third accepted", v, 8'h97);
  endtask

  initial begin
    port_en = 1'b1; sync_mode = 1'b1; clk_src = 1'b0; cont_rx = 1'b1;
    single_rx = 1'b0; nine_bit = 1'b0; rx_ie = 1'b0;
    sclk = 1'b0; sdata = 1'b0; rd_en = 1'b0; rd_addr = 1'b0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_basic8();
    t_nine();
    t_gate();
    t_two_deep_irq();
    t_overrun();
    t_abandon();
    t_collide();
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_vec++;
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule